// File: doc/BRIEF.md
# 64-bit Global Timer with Comparator

A free-running 64-bit up-counter that software controls through a small 32-bit word register port. A 64-bit compare value sits next to it. When the comparator is enabled and the counter reaches or passes the compare value, an event flag is raised. The flag can drive a level interrupt line. An optional reload adds a 32-bit step to the compare value on every event, so the timer can produce a steady series of ticks without software reprogramming the comparator each time.

Software reads the counter as two 32-bit halves. The low-to-high carry and the high half are updated in the same cycle, so a high/low/high read sequence always yields a consistent pair. Reads take data combinationally from the register selected by the address while the read enable is high. Writes take effect at the next clock edge.

Top module: `glb_timer`

## Requirements
- R1: After reset every register reads zero: the counter is stopped, the comparator, interrupt and reload are off, the event flag is clear, and `irq_o` is low.
- R2: While control bit 0 is 1 the counter adds one on every clock edge. While it is 0 the counter holds its value.
- R3: A write to the counter low word (offset 0x00) or the high word (0x04) loads that half and leaves the other half unchanged.
- R4: When the low word wraps from all ones, the high word increments on the same edge, so both halves read back consistently.
- R5: With control bit 1 set, an event raises status bit 0 when the unsigned 64-bit counter is greater than or equal to the 64-bit compare value (low word 0x10, high word 0x14). A compare value already behind the counter also fires. With bit 1 clear, no event occurs.
- R6: An event occurs only in the cycle where the match condition turns true. A match that stays true does not raise the flag again after it is cleared.
- R7: Writing 1 to status bit 0 (offset 0x0C) clears the flag, and writing 0 leaves it alone. If an event occurs in the same cycle as the clear, the flag stays set.
- R8: With control bit 3 set, each event adds the 32-bit reload value (offset 0x18) to the 64-bit compare value.
- R9: `irq_o` is high exactly when the event flag is set and control bit 2 is set.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.
- R11: In a cycle that writes the control word (offset 0x08) with bit 1 set, no event is taken. A match that becomes true in that cycle is taken on the next cycle instead.
- R12: Control reads back bits 3:0 with the upper bits zero. Status reads back the flag in bit 0. The compare and reload registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW (5) | Byte offset of the register |
| wdata_i | input | DW (32) | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | DW (32) | Read data, zero when `re_i` is low |
| irq_o | output | 1 | Level interrupt |
| event_o | output | 1 | Event flag |

## Verification
The comparator is tried against random 64-bit counter and compare pairs. The high halves of each pair are picked at one below, equal to, and one above each other, so a compare that works on only one half, or that tests for equality instead of greater-or-equal, gives a different flag. Directed cases hold the counter stopped so the exact edge of each event is known. These cases separate a deferred event from a suppressed one, and a clear that wins a collision with an event from one that loses it. A low-word wrap while counting shows whether the carry reaches the high half on the same edge. A run with the reload enabled counts the events through the final compare value.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int unsigned OFS_CNT_LO = 'h00;
  localparam int unsigned OFS_CNT_HI = 'h04;
  localparam int unsigned OFS_CTRL   = 'h08;
  localparam int unsigned OFS_STAT   = 'h0C;
  localparam int unsigned OFS_CMP_LO = 'h10;
  localparam int unsigned OFS_CMP_HI = 'h14;
  localparam int unsigned OFS_RELOAD = 'h18;

  localparam int unsigned CTRL_CMP_BIT = 1;
  localparam int unsigned STAT_FLG_BIT = 0;

  // packed MSB first: field order gives bit 3..0
  typedef struct packed {
    logic auto_inc;
    logic irq_en;
    logic cmp_en;
    logic cnt_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] cnt_o
);
  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0] cnt_q;

  // single full-width register: carry into the high half lands on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_lo_i) cnt_q <= {cnt_q[CW-1:DW], wdata_i};
    else if (wr_hi_i) cnt_q <= {wdata_i, cnt_q[DW-1:0]};
    else if (en_i)    cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gt_match.sv
module gt_match #(
  parameter int unsigned CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          cmp_en_i,
  input  logic          suppress_i,
  input  logic          clr_i,
  output logic          evt_o,
  output logic          flag_o
);
  logic raw_match;
  logic match_q;
  logic flag_q;

  assign raw_match = cmp_en_i && (cnt_i >= cmp_i);
  assign evt_o     = raw_match && !match_q && !suppress_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      // hold history during a suppressed cycle so the edge is deferred, not lost
      if (!suppress_i) match_q <= raw_match;
      flag_q <= evt_o || (flag_q && !clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              re_i,
  input  logic [2*DW-1:0]   cnt_i,
  input  logic              flag_i,
  input  logic              evt_i,
  output ctrl_t             ctrl_o,
  output logic [2*DW-1:0]   cmp_o,
  output logic [DW-1:0]     rdata_o,
  output logic              wr_cnt_lo_o,
  output logic              wr_cnt_hi_o,
  output logic              suppress_o,
  output logic              clr_o
);
  localparam int unsigned CW = 2 * DW;

  ctrl_t         ctrl_q;
  logic [CW-1:0] cmp_q, cmp_d;
  logic [DW-1:0] rld_q;

  logic hit_ctrl, hit_stat, hit_cmp_lo, hit_cmp_hi, hit_rld;

  assign wr_cnt_lo_o = we_i && (addr_i == AW'(OFS_CNT_LO));
  assign wr_cnt_hi_o = we_i && (addr_i == AW'(OFS_CNT_HI));
  assign hit_ctrl    = we_i && (addr_i == AW'(OFS_CTRL));
  assign hit_stat    = we_i && (addr_i == AW'(OFS_STAT));
  assign hit_cmp_lo  = we_i && (addr_i == AW'(OFS_CMP_LO));
  assign hit_cmp_hi  = we_i && (addr_i == AW'(OFS_CMP_HI));
  assign hit_rld     = we_i && (addr_i == AW'(OFS_RELOAD));

  assign suppress_o = hit_ctrl && wdata_i[CTRL_CMP_BIT];
  assign clr_o      = hit_stat && wdata_i[STAT_FLG_BIT];

  // software write to a compare half wins over the reload step
  always_comb begin
    cmp_d = cmp_q;
    if (hit_cmp_lo)                    cmp_d[DW-1:0]  = wdata_i;
    else if (hit_cmp_hi)               cmp_d[CW-1:DW] = wdata_i;
    else if (evt_i && ctrl_q.auto_inc) cmp_d = cmp_q + CW'(rld_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (hit_rld)  rld_q  <= wdata_i;
      cmp_q <= cmp_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      case (addr_i)
        AW'(OFS_CNT_LO): rdata_o = cnt_i[DW-1:0];
        AW'(OFS_CNT_HI): rdata_o = cnt_i[CW-1:DW];
        AW'(OFS_CTRL):   rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
        AW'(OFS_STAT):   rdata_o = {{(DW-1){1'b0}}, flag_i};
        AW'(OFS_CMP_LO): rdata_o = cmp_q[DW-1:0];
        AW'(OFS_CMP_HI): rdata_o = cmp_q[CW-1:DW];
        AW'(OFS_RELOAD): rdata_o = rld_q;
        default:         rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/glb_timer.sv
module glb_timer
  import gt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          event_o
);
  localparam int unsigned CW = 2 * DW;

  ctrl_t         ctrl;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cmp;
  logic          wr_cnt_lo, wr_cnt_hi, suppress, clr, evt, flag;

  gt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .re_i        (re_i),
    .cnt_i       (cnt),
    .flag_i      (flag),
    .evt_i       (evt),
    .ctrl_o      (ctrl),
    .cmp_o       (cmp),
    .rdata_o     (rdata_o),
    .wr_cnt_lo_o (wr_cnt_lo),
    .wr_cnt_hi_o (wr_cnt_hi),
    .suppress_o  (suppress),
    .clr_o       (clr)
  );

  gt_counter #(.DW(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.cnt_en),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  gt_match #(.CW(CW)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .cmp_i      (cmp),
    .cmp_en_i   (ctrl.cmp_en),
    .suppress_i (suppress),
    .clr_i      (clr),
    .evt_o      (evt),
    .flag_o     (flag)
  );

  assign event_o = flag;
  assign irq_o   = flag && ctrl.irq_en;
endmodule

// File: rtl/gt_checker.sv
module gt_checker
  import gt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            re_i,
  input logic [DW-1:0]   rdata_o,
  input logic            irq_o,
  input logic            event_o,
  input logic            cnt_en_i,
  input logic            cmp_en_i,
  input logic [2*DW-1:0] cnt_i
);
  localparam int unsigned CW = 2 * DW;

  logic wr_cnt, wr_ctrl_cmp, clr_req, unmapped;

  assign wr_cnt      = we_i && (addr_i == AW'(OFS_CNT_LO) || addr_i == AW'(OFS_CNT_HI));
  assign wr_ctrl_cmp = we_i && addr_i == AW'(OFS_CTRL) && wdata_i[CTRL_CMP_BIT];
  assign clr_req     = we_i && addr_i == AW'(OFS_STAT) && wdata_i[STAT_FLG_BIT];
  assign unmapped    = !(addr_i inside {AW'(OFS_CNT_LO), AW'(OFS_CNT_HI), AW'(OFS_CTRL),
                         AW'(OFS_STAT), AW'(OFS_CMP_LO), AW'(OFS_CMP_HI), AW'(OFS_RELOAD)});

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !wr_cnt) |=> cnt_i == $past(cnt_i) + CW'(1)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !wr_cnt) |=> $stable(cnt_i)); // R2

  AST_CARRY_SAME_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !wr_cnt && cnt_i[DW-1:0] == '1) |=>
      (cnt_i[DW-1:0] == '0 && cnt_i[CW-1:DW] == $past(cnt_i[CW-1:DW]) + DW'(1))); // R4

  AST_NO_EVT_CMP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!event_o && !cmp_en_i) |=> !event_o); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !clr_req) |=> event_o); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> event_o); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && unmapped) |-> rdata_o == '0); // R10

  AST_SUPPRESS_CTRL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!event_o && wr_ctrl_cmp) |=> !event_o); // R11
endmodule

bind glb_timer gt_checker #(.DW(DW), .AW(AW)) u_gt_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .event_o  (event_o),
  .cnt_en_i (ctrl.cnt_en),
  .cmp_en_i (ctrl.cmp_en),
  .cnt_i    (cnt)
);

// File: tb/test_glb_timer.sv
module test_glb_timer;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_STA = 5'h0C,
                            A_MLO = 5'h10, A_MHI = 5'h14, A_RLD = 5'h18, A_BAD = 5'h1C;
  localparam logic [31:0] C_CNT = 32'h1, C_CMP = 32'h2, C_IRQ = 32'h4, C_AUTO = 32'h8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          re_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          irq_o, event_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  glb_timer #(.DW(DW), .AW(AW)) i_glb_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .re_i(re_i), .rdata_o(rdata_o), .irq_o(irq_o), .event_o(event_o)
  );

  function automatic logic ge64(input logic [63:0] a, input logic [63:0] b);
    return a >= b;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1;
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1;
    d = rdata_o;
    re_i = 1'b0;
  endtask

  task automatic rd64(input logic [AW-1:0] lo_a, output logic [63:0] v);
    logic [31:0] h0, l, h1;
    rd(lo_a + AW'(4), h0);
    rd(lo_a, l);
    rd(lo_a + AW'(4), h1);
    if (h0 != h1) rd(lo_a, l);
    v = {h1, l};
  endtask

  task automatic set64(input logic [AW-1:0] lo_a, input logic [63:0] v);
    wr(lo_a, v[31:0]);
    wr(lo_a + AW'(4), v[63:32]);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v, base;
    void'($urandom(32'd20240611));

    #7 rst_ni = 1'b1;

    // R1 reset state
    @(negedge clk_i);
    chk("R1 event", {63'd0, event_o}, 64'd0);
    chk("R1 irq", {63'd0, irq_o}, 64'd0);
    for (int i = 0; i < 7; i++) begin
      rd(AW'(i * 4), d);
      chk("R1 regs zero", {32'd0, d}, 64'd0);
    end

    // R12 register map readback
    wr(A_CTL, 32'hFFFF_FFF0 | C_IRQ);
    rd(A_CTL, d);  chk("R12 ctrl mask", {32'd0, d}, 64'h4);
    wr(A_CTL, 32'h0);
    wr(A_RLD, 32'hDEAD_BEEF);
    rd(A_RLD, d);  chk("R12 reload", {32'd0, d}, 64'hDEAD_BEEF);
    set64(A_MLO, 64'h1234_5678_9ABC_DEF0);
    rd64(A_MLO, v); chk("R12 compare", v, 64'h1234_5678_9ABC_DEF0);

    // R3 half writes
    set64(A_CLO, 64'h0000_0011_0000_0022);
    wr(A_CLO, 32'hAAAA_5555);
    rd64(A_CLO, v); chk("R3 low half only", v, 64'h0000_0011_AAAA_5555);
    wr(A_CHI, 32'h0000_0099);
    rd64(A_CLO, v); chk("R3 high half only", v, 64'h0000_0099_AAAA_5555);

    // R2 count and halt
    set64(A_CLO, 64'h100);
    wr(A_CTL, C_CNT);
    repeat (9) @(posedge clk_i);
    wr(A_CTL, 32'h0);
    rd64(A_CLO, v); chk("R2 ten increments", v, 64'h10A);
    repeat (5) @(posedge clk_i);
    rd64(A_CLO, v); chk("R2 halted", v, 64'h10A);

    // R4 carry across halves
    set64(A_CLO, 64'h0000_0007_FFFF_FFFE);
    wr(A_CTL, C_CNT);
    repeat (4) @(posedge clk_i);
    wr(A_CTL, 32'h0);
    rd64(A_CLO, v); chk("R4 carry", v, 64'h0000_0008_0000_0003);

    // R5 exact event edge with stopped counter, R9 irq
    base = 64'h0000_0003_0000_1000;
    set64(A_CLO, base);
    set64(A_MLO, base + 64'd5);
    wr(A_CTL, C_CMP | C_IRQ);
    repeat (3) @(posedge clk_i);
    #1 chk("R5 below compare", {63'd0, event_o}, 64'd0);
    wr(A_MLO, base[31:0]);
    #0 chk("R5 not before match seen", {63'd0, event_o}, 64'd0);
    @(posedge clk_i); #1;
    chk("R5 equal fires", {63'd0, event_o}, 64'd1);
    chk("R9 irq with enable", {63'd0, irq_o}, 64'd1);
    wr(A_CTL, C_CMP);
    #0 chk("R9 irq masked", {63'd0, irq_o}, 64'd0);
    rd(A_STA, d); chk("R12 status flag", {32'd0, d}, 64'd1);

    // R6 held match does not re-raise after clear; R7 clear with 0 ignored
    wr(A_STA, 32'h0);
    #0 chk("R7 write 0 keeps", {63'd0, event_o}, 64'd1);
    wr(A_STA, 32'h1);
    repeat (3) @(posedge clk_i);
    #1 chk("R6 no re-raise", {63'd0, event_o}, 64'd0);

    // R7 collision: event and clear in the same cycle
    wr(A_CTL, 32'h0);
    repeat (2) @(posedge clk_i);
    wr(A_CTL, C_CMP);
    wr(A_STA, 32'h1);
    #0 chk("R7 event beats clear", {63'd0, event_o}, 64'd1);
    wr(A_STA, 32'h1);
    #0 chk("R7 plain clear", {63'd0, event_o}, 64'd0);

    // R11 control write defers a match that rises in the same cycle
    set64(A_MLO, base + 64'd100);
    repeat (2) @(posedge clk_i);
    wr(A_MLO, base[31:0]);
    wr(A_CTL, C_CMP);
    #0 chk("R11 suppressed cycle", {63'd0, event_o}, 64'd0);
    @(posedge clk_i); #1;
    chk("R11 deferred event", {63'd0, event_o}, 64'd1);
    wr(A_CTL, 32'h0);
    wr(A_STA, 32'h1);

    // R5 compare disabled: no event even when past compare
    set64(A_MLO, 64'd0);
    repeat (3) @(posedge clk_i);
    #1 chk("R5 disabled no event", {63'd0, event_o}, 64'd0);

    // R8 reload: one event when enabling, then two while counting
    set64(A_CLO, base);
    set64(A_MLO, base);
    wr(A_RLD, 32'd10);
    wr(A_CTL, C_CMP | C_AUTO);
    @(posedge clk_i); #1;
    chk("R8 first event", {63'd0, event_o}, 64'd1);
    rd64(A_MLO, v); chk("R8 compare stepped", v, base + 64'd10);
    wr(A_STA, 32'h1);
    wr(A_CTL, C_CNT | C_CMP | C_AUTO);
    repeat (24) @(posedge clk_i);
    wr(A_CTL, C_CMP | C_AUTO);
    rd64(A_CLO, v); chk("R8 counter run", v, base + 64'd25);
    rd64(A_MLO, v); chk("R8 two more steps", v, base + 64'd30);
    chk("R8 flag from run", {63'd0, event_o}, 64'd1);
    wr(A_CTL, 32'h0);
    wr(A_STA, 32'h1);

    // R10 unmapped offset
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, d); chk("R10 unmapped read", {32'd0, d}, 64'd0);
    rd(A_RLD, d); chk("R10 reload untouched", {32'd0, d}, 64'd10);
    rd(A_CTL, d); chk("R10 ctrl untouched", {32'd0, d}, 64'd0);
    rd64(A_CLO, v); chk("R10 counter untouched", v, base + 64'd25);

    // R5 random 64-bit greater-or-equal, high halves near each other
    for (int t = 0; t < 40; t++) begin
      logic [63:0] c, m;
      logic [31:0] hi;
      hi = $urandom | 32'h1;
      c  = {hi, $urandom()};
      m  = {hi + 32'($urandom_range(2)) - 32'd1, $urandom()};
      if (t % 8 == 0) m = c;
      set64(A_CLO, c);
      set64(A_MLO, m);
      wr(A_CTL, C_CMP);
      @(posedge clk_i); #1;
      chk("R5 random ge", {63'd0, event_o}, {63'd0, ge64(c, m)});
      wr(A_CTL, 32'h0);
      wr(A_STA, 32'h1);
      #0 chk("R7 random clear", {63'd0, event_o}, 64'd0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule